// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a synchronous request port and a 1M x 16 extended-data-out DRAM. Each request carries a 20-bit word address, a direction, two byte enables, 16 bits of write data and a flag that asks for the row to stay open. The controller splits the address into a 12-bit row and an 8-bit column, sends them one after the other on a shared 12-bit address bus, and drives the row strobe, the two byte column strobes, write enable and output enable. All timing is counted in clock cycles, and each interval has its own parameter.

When a request with the keep-open flag set is followed by a request to the same row, the controller goes straight to the column phase and leaves the row strobe low. A request to another row, a request without the flag, or the row-open time limit closes the page. The controller then raises the row strobe and waits out the precharge time before the next row opens. Writes always use the early-write form: write enable goes low one cycle before the column strobes fall. Read data is sampled on the edge where the column strobes rise and is returned with a one-cycle valid pulse. Refresh is handled by a separate sequencer and is not part of this block.

Top module: `edoc_ctrl`

## Requirements
- R1: After reset, the row strobe, both column strobes, write enable and output enable are high (all active low), no data lane is driven, `rd_valid` is 0 and `req_ready` is 1.
- R2: When the row strobe falls, `dram_addr` carries the row, which is `req_addr[19:8]`. When a column strobe falls, `dram_addr[7:0]` carries the column, which is `req_addr[7:0]`, and `dram_addr[11:8]` is zero.
- R3: Byte enable bit 0 selects data bits 7:0 and the lower strobe `dram_lcas_n`. Bit 1 selects bits 15:8 and the upper strobe `dram_ucas_n`. The strobe of an unselected byte stays high for the whole access.
- R4: In a write, `dram_we_n` is low at least one cycle before a column strobe falls. `dram_oe_n` stays high, and `dram_dq_oe[b]` is set only for selected bytes and only while `dram_we_n` is low.
- R5: In a read, `dram_oe_n` is low while the strobes are low. `rd_valid` is high for exactly one cycle, the cycle after the strobes rise. `rd_data` then holds the DRAM data for the selected bytes, and unselected bytes read as zero.
- R6: A column strobe is low only while the row strobe is low. The first column strobe after a row opens falls at least T_RCD_CYC+1 cycles after the row strobe falls. The column strobes stay low for exactly T_CAS_CYC cycles. Within one open row, both strobes are high for at least T_CP_CYC cycles between two accesses.
- R7: Between two row openings, the row strobe stays high for at least T_RP_CYC cycles.
- R8: When an access has the keep-open flag set and the next request is to the same row, the next access runs without a new row-strobe fall.
- R9: After an access whose keep-open flag is clear, the controller raises the row strobe.
- R10: If a request to a different row arrives while a row is open, the controller closes the row, waits out precharge, and opens the new row.
- R11: The row strobe never stays low for more than RAS_MAX_CYC cycles. The page closes before that limit even if the keep-open flag is set.
- R12: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after a request is taken, and each taken request produces exactly one column-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper 12 bits |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| req_burst | input | 1 | Keep the row open after this access |
| rd_valid | output | 1 | One-cycle pulse: read data returned |
| rd_data | output | 16 | Read data, unselected bytes are zero |
| dram_addr | output | 12 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe |
| dram_ucas_n | output | 1 | Upper byte column strobe |
| dram_lcas_n | output | 1 | Lower byte column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 2 | Per-byte drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The checker is evaluated on every cycle. It covers the strobe spacings: row-to-column delay, column-strobe width, column precharge within a page, and row precharge. It also checks the row-open limit, the ordering of write enable against the column strobes, the rule that output enable stays high during writes, the one-cycle read pulse and the handshake. Only the bench's scenarios, run against a behavioural memory, can show the other behaviours: correct row and column values on the bus, byte-masked writes that leave the other byte intact, zeroed unselected read bytes, and how many row openings happen for page hits, row misses and a long keep-open burst.

// File: rtl/edoc_pkg.sv
package edoc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RAS,
      ST_COL,
      ST_CAS,
      ST_CP,
      ST_OPEN,
      ST_CLOSE
   } edoc_state_e;

   function automatic int unsigned edoc_max4(int unsigned a, int unsigned b,
                                             int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/edoc_addr_split.sv
module edoc_addr_split #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned ROW_W  = 12,
   parameter int unsigned COL_W  = 8,
   parameter int unsigned PIN_W  = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [PIN_W-1:0]  row_pins,
   output logic [PIN_W-1:0]  col_pins
);
   if (ADDR_W != ROW_W + COL_W) begin : g_bad_split
      $error("edoc_addr_split: ADDR_W must equal ROW_W + COL_W");
   end
   if (PIN_W < ROW_W || PIN_W < COL_W) begin : g_bad_pins
      $error("edoc_addr_split: PIN_W too narrow");
   end

   // row field is the upper part of the word address
   if (PIN_W > ROW_W) begin : g_row_pad
      assign row_pins = {{(PIN_W-ROW_W){1'b0}}, addr[ADDR_W-1 -: ROW_W]};
   end else begin : g_row_full
      assign row_pins = addr[ADDR_W-1 -: ROW_W];
   end

   if (PIN_W > COL_W) begin : g_col_pad
      assign col_pins = {{(PIN_W-COL_W){1'b0}}, addr[COL_W-1:0]};
   end else begin : g_col_full
      assign col_pins = addr[COL_W-1:0];
   end
endmodule

// File: rtl/edoc_dwn.sv
module edoc_dwn #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/edoc_ras_age.sv
module edoc_ras_age #(
   parameter int unsigned LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_low,
   output logic expired
);
   localparam int unsigned AGE_W = $clog2(LIMIT + 1);

   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= '0;
      end else if (!ras_low) begin
         age_q <= '0;
      end else if (age_q < AGE_W'(LIMIT)) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign expired = (age_q >= AGE_W'(LIMIT));
endmodule

// File: rtl/edoc_ctrl.sv
module edoc_ctrl
   import edoc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned ROW_W       = 12,
   parameter int unsigned COL_W       = 8,
   parameter int unsigned PIN_W       = 12,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned T_RCD_CYC   = 2,
   parameter int unsigned T_CAS_CYC   = 2,
   parameter int unsigned T_CP_CYC    = 2,
   parameter int unsigned T_RP_CYC    = 5,
   parameter int unsigned RAS_MAX_CYC = 12500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                req_burst,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic [PIN_W-1:0]    dram_addr,
   output logic                dram_ras_n,
   output logic                dram_ucas_n,
   output logic                dram_lcas_n,
   output logic                dram_we_n,
   output logic                dram_oe_n,
   output logic [DATA_W-1:0]   dram_dq_out,
   output logic [DATA_W/8-1:0] dram_dq_oe,
   input  logic [DATA_W-1:0]   dram_dq_in
);
   localparam int unsigned NBYTE    = DATA_W / 8;
   localparam int unsigned PAGE_CYC = 2 + T_CAS_CYC + T_CP_CYC;
   localparam int unsigned AGE_LIM  = RAS_MAX_CYC - PAGE_CYC;
   localparam int unsigned MAX_DUR  = edoc_max4(T_RCD_CYC, T_CAS_CYC, T_CP_CYC, T_RP_CYC);
   localparam int unsigned TMR_W    = $clog2(MAX_DUR + 1);

   if (NBYTE != 2 || DATA_W != 16) begin : g_bad_width
      $error("edoc_ctrl: two byte lanes of 8 bits are required");
   end
   if (T_RCD_CYC < 1 || T_CAS_CYC < 1 || T_CP_CYC < 1 || T_RP_CYC < 1) begin : g_bad_time
      $error("edoc_ctrl: every timing count must be at least one cycle");
   end
   if (RAS_MAX_CYC < T_RCD_CYC + 2 * PAGE_CYC) begin : g_bad_rasmax
      $error("edoc_ctrl: RAS_MAX_CYC too small for one access plus one page hit");
   end

   edoc_state_e       state_q, state_d;
   logic              wr_q, burst_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NBYTE-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [PIN_W-1:0]  row_pins, col_pins;
   logic              tmr_last, age_expired, same_row, accept;
   logic              in_cas, drv_col, ras_low;
   logic [NBYTE-1:0]  cas_lane_n;
   logic [DATA_W-1:0] rd_masked;

   function automatic logic [TMR_W-1:0] dur_of(edoc_state_e s);
      case (s)
         ST_RAS:   return TMR_W'(T_RCD_CYC - 1);
         ST_CAS:   return TMR_W'(T_CAS_CYC - 1);
         ST_CP:    return TMR_W'(T_CP_CYC - 1);
         ST_CLOSE: return TMR_W'(T_RP_CYC - 1);
         default:  return '0;
      endcase
   endfunction

   edoc_addr_split #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)
   ) u_split (
      .addr     (addr_q),
      .row_pins (row_pins),
      .col_pins (col_pins)
   );

   edoc_dwn #(.W(TMR_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_d != state_q),
      .load_val (dur_of(state_d)),
      .last     (tmr_last)
   );

   edoc_ras_age #(.LIMIT(AGE_LIM)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_low (ras_low),
      .expired (age_expired)
   );

   assign same_row  = (req_addr[ADDR_W-1 -: ROW_W] == addr_q[ADDR_W-1 -: ROW_W]);
   assign req_ready = (state_q == ST_IDLE) ||
                      (state_q == ST_OPEN && same_row && !age_expired);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_RAS;
         ST_RAS:   if (tmr_last) state_d = ST_COL;
         ST_COL:   state_d = ST_CAS;
         ST_CAS:   if (tmr_last) state_d = ST_CP;
         ST_CP:    if (tmr_last) state_d = burst_q ? ST_OPEN : ST_CLOSE;
         ST_OPEN: begin
            if (accept)                        state_d = ST_COL;
            else if (req_valid || age_expired) state_d = ST_CLOSE;
         end
         ST_CLOSE: if (tmr_last) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         burst_q <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            wr_q    <= req_write;
            burst_q <= req_burst;
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
         end
      end
   end

   // read data is taken on the edge that ends the strobe-low phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= in_cas && tmr_last && !wr_q;
         if (in_cas && tmr_last && !wr_q) begin
            rd_data_q <= rd_masked;
         end
      end
   end

   assign in_cas  = (state_q == ST_CAS);
   assign drv_col = (state_q == ST_COL) || in_cas;
   assign ras_low = (state_q != ST_IDLE) && (state_q != ST_CLOSE);

   for (genvar b = 0; b < NBYTE; b++) begin : g_lane
      assign cas_lane_n[b]       = !(in_cas && be_q[b]);
      assign dram_dq_oe[b]       = wr_q && be_q[b] && drv_col;
      assign rd_masked[b*8 +: 8] = be_q[b] ? dram_dq_in[b*8 +: 8] : 8'h00;
   end

   assign dram_lcas_n = cas_lane_n[0];
   assign dram_ucas_n = cas_lane_n[NBYTE-1];
   assign dram_ras_n  = !ras_low;
   assign dram_addr   = drv_col ? col_pins : row_pins;
   assign dram_we_n   = !(wr_q && drv_col);
   assign dram_oe_n   = !(!wr_q && in_cas);
   assign dram_dq_out = wdata_q;
   assign rd_valid    = rd_valid_q;
   assign rd_data     = rd_data_q;
endmodule

// File: rtl/edoc_ctrl_chk.sv
module edoc_ctrl_chk #(
   parameter int unsigned T_RCD_CYC   = 2,
   parameter int unsigned T_CAS_CYC   = 2,
   parameter int unsigned T_CP_CYC    = 2,
   parameter int unsigned T_RP_CYC    = 5,
   parameter int unsigned RAS_MAX_CYC = 12500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rd_valid,
   input logic       dram_ras_n,
   input logic       dram_ucas_n,
   input logic       dram_lcas_n,
   input logic       dram_we_n,
   input logic       dram_oe_n,
   input logic [1:0] dram_dq_oe
);
   logic        cas_any_low;
   logic [31:0] ras_hi_run, ras_lo_run, cas_hi_run, cas_lo_run;
   logic        seen_ras_low, cas_in_row;

   assign cas_any_low = !dram_ucas_n || !dram_lcas_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_hi_run   <= '0;
         ras_lo_run   <= '0;
         cas_hi_run   <= '0;
         cas_lo_run   <= '0;
         seen_ras_low <= 1'b0;
         cas_in_row   <= 1'b0;
      end else begin
         ras_hi_run <= dram_ras_n ? ras_hi_run + 32'd1 : 32'd0;
         ras_lo_run <= dram_ras_n ? 32'd0 : ras_lo_run + 32'd1;
         cas_hi_run <= cas_any_low ? 32'd0 : cas_hi_run + 32'd1;
         cas_lo_run <= cas_any_low ? cas_lo_run + 32'd1 : 32'd0;
         if (!dram_ras_n) seen_ras_low <= 1'b1;
         if (dram_ras_n)       cas_in_row <= 1'b0;
         else if (cas_any_low) cas_in_row <= 1'b1;
      end
   end

   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      cas_any_low |-> !dram_ras_n); // R6
   AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_any_low) && !cas_in_row) |-> (ras_lo_run >= T_RCD_CYC + 1)); // R6
   AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_any_low) |-> (cas_lo_run == T_CAS_CYC)); // R6
   AST_CP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_any_low) && cas_in_row) |-> (cas_hi_run >= T_CP_CYC)); // R6
   AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && seen_ras_low) |-> (ras_hi_run >= T_RP_CYC)); // R7
   AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> (ras_lo_run < RAS_MAX_CYC)); // R11
   AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_any_low) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0)); // R4
   AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> dram_oe_n); // R4
   AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_dq_oe != 2'b00) |-> !dram_we_n); // R4
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R5
   AST_TAKE_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R12
endmodule

bind edoc_ctrl edoc_ctrl_chk #(
   .T_RCD_CYC   (T_RCD_CYC),
   .T_CAS_CYC   (T_CAS_CYC),
   .T_CP_CYC    (T_CP_CYC),
   .T_RP_CYC    (T_RP_CYC),
   .RAS_MAX_CYC (RAS_MAX_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rd_valid    (rd_valid),
   .dram_ras_n  (dram_ras_n),
   .dram_ucas_n (dram_ucas_n),
   .dram_lcas_n (dram_lcas_n),
   .dram_we_n   (dram_we_n),
   .dram_oe_n   (dram_oe_n),
   .dram_dq_oe  (dram_dq_oe)
);

// File: tb/edoc_ctrl_tb.sv
module edoc_ctrl_tb_top;
   localparam int TB_RCD = 2;
   localparam int TB_CAS = 2;
   localparam int TB_CP  = 2;
   localparam int TB_RP  = 5;
   localparam int TB_MAX = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
   logic [19:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [15:0] rd_data;
   logic [11:0] dram_addr;
   logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;
   logic [15:0] dram_dq_out, dram_dq_in;
   logic [1:0]  dram_dq_oe;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   edoc_ctrl #(
      .T_RCD_CYC(TB_RCD), .T_CAS_CYC(TB_CAS), .T_CP_CYC(TB_CP),
      .T_RP_CYC(TB_RP), .RAS_MAX_CYC(TB_MAX)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .req_burst(req_burst), .rd_valid(rd_valid),
      .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
      .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   // ---------------- behavioural DRAM ----------------
   logic [15:0] mem [int unsigned];
   logic [11:0] m_row = '0;
   logic [7:0]  m_col = '0;

   function automatic logic [15:0] get_w(int unsigned k);
      return mem.exists(k) ? mem[k] : 16'h0000;
   endfunction

   always @(negedge dram_ras_n) m_row = dram_addr;
   always @(negedge dram_lcas_n) begin
      m_col = dram_addr[7:0];
      if (!dram_we_n) begin
         mem[{m_row, dram_addr[7:0]}] = {get_w({m_row, dram_addr[7:0]})[15:8], dram_dq_out[7:0]};
      end
   end
   always @(negedge dram_ucas_n) begin
      m_col = dram_addr[7:0];
      if (!dram_we_n) begin
         mem[{m_row, dram_addr[7:0]}] = {dram_dq_out[15:8], get_w({m_row, dram_addr[7:0]})[7:0]};
      end
   end
   always @* begin
      dram_dq_in = 16'h0000;
      if (!dram_oe_n && dram_we_n && (!dram_lcas_n || !dram_ucas_n))
         dram_dq_in = get_w({m_row, m_col});
   end

   // ---------------- monitor (samples mid-cycle) ----------------
   int ras_falls = 0, cas_falls = 0, rdv_cnt = 0;
   int lo_run = 0, hi_run = 0, max_low = 0, cas_lo = 0, cas_hi = 0;
   int sp_bad = 0, rp_bad = 0, early_bad = 0, wr_oe_bad = 0;
   bit seen_low = 0, cas_in_row = 0, seen_l = 0, seen_u = 0;
   bit prev_ras = 1, prev_cas = 0, prev_we = 1;
   logic [11:0] mon_row = '0;
   logic [7:0]  mon_col = '0;
   logic [15:0] last_rd = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit cl;
         cl = !dram_ucas_n || !dram_lcas_n;
         if (cl && !prev_cas) begin
            cas_falls++;
            mon_col = dram_addr[7:0];
            if (dram_addr[11:8] != 4'h0) sp_bad++;
            if (!cas_in_row && lo_run < TB_RCD + 1) sp_bad++;
            if (cas_in_row && cas_hi < TB_CP) sp_bad++;
            if (!dram_we_n && prev_we) early_bad++;
         end
         if (!cl && prev_cas && cas_lo != TB_CAS) sp_bad++;
         if (cl && dram_ras_n) sp_bad++;
         if (cl) begin cas_lo++; cas_hi = 0; end else begin cas_hi++; cas_lo = 0; end
         if (!dram_ras_n && prev_ras) begin
            ras_falls++;
            mon_row = dram_addr;
            if (seen_low && hi_run < TB_RP) rp_bad++;
         end
         if (dram_ras_n) begin
            hi_run++; lo_run = 0; cas_in_row = 0;
         end else begin
            lo_run++; hi_run = 0; seen_low = 1;
            if (lo_run > max_low) max_low = lo_run;
            if (cl) cas_in_row = 1;
         end
         if (!dram_we_n && !dram_oe_n) wr_oe_bad++;
         if (!dram_lcas_n) seen_l = 1;
         if (!dram_ucas_n) seen_u = 1;
         if (rd_valid) begin rdv_cnt++; last_rd = rd_data; end
         prev_ras = dram_ras_n; prev_cas = cl; prev_we = dram_we_n;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input bit wr, input logic [19:0] a, input logic [1:0] be,
                         input logic [15:0] d, input bit burst);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
      req_wdata = d; req_burst = burst;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_read(input logic [19:0] a, input logic [1:0] be, input bit burst,
                          output logic [15:0] d);
      int c0;
      c0 = rdv_cnt;
      do_req(1'b0, a, be, 16'h0, burst);
      for (int i = 0; i < 40 && rdv_cnt == c0; i++) begin @(negedge clk); #1; end
      chk("R5 read pulse seen", 32'(rdv_cnt - c0), 32'd1);
      d = last_rd;
      @(negedge clk); #1;
      chk("R5 pulse lasts one cycle", 32'(rdv_cnt - c0), 32'd1);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      @(negedge clk); #1;
      chk("R1 reset outputs",
          32'({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid, req_ready}),
          32'(9'b11111_00_0_1));
   endtask

   task automatic t_write_read;
      logic [15:0] d;
      do_req(1'b1, 20'hABCDE, 2'b11, 16'h1234, 1'b0);
      settle(12);
      chk("R2 row on bus", 32'(mon_row), 32'h0ABC);
      chk("R2 column on bus", 32'(mon_col), 32'h00DE);
      chk("R4 WE low before strobe", 32'(early_bad), 32'd0);
      chk("R4 OE high during write", 32'(wr_oe_bad), 32'd0);
      do_read(20'hABCDE, 2'b11, 1'b0, d);
      chk("R5 word readback", 32'(d), 32'h1234);
      settle(10);
   endtask

   task automatic t_byte_lanes;
      logic [15:0] d;
      do_req(1'b1, 20'h12345, 2'b11, 16'hAAAA, 1'b0);
      settle(12);
      seen_l = 0; seen_u = 0;
      do_req(1'b1, 20'h12345, 2'b01, 16'h5511, 1'b0);
      settle(12);
      chk("R3 lower-only write strobes {u,l}", 32'({seen_u, seen_l}), 32'(2'b01));
      do_read(20'h12345, 2'b11, 1'b0, d);
      chk("R3 lower byte write keeps upper", 32'(d), 32'hAA11);
      settle(10);
      seen_l = 0; seen_u = 0;
      do_read(20'h12345, 2'b10, 1'b0, d);
      chk("R5 unselected byte reads zero", 32'(d), 32'hAA00);
      chk("R3 upper-only read strobes {u,l}", 32'({seen_u, seen_l}), 32'(2'b10));
      settle(10);
      do_req(1'b1, 20'h12345, 2'b10, 16'h77EE, 1'b0);
      settle(12);
      do_read(20'h12345, 2'b11, 1'b0, d);
      chk("R3 upper byte write keeps lower", 32'(d), 32'h7711);
      settle(10);
   endtask

   task automatic t_page_hit;
      int f0;
      logic [15:0] d;
      f0 = ras_falls;
      do_req(1'b1, 20'h05501, 2'b11, 16'hC001, 1'b1);
      do_req(1'b1, 20'h05502, 2'b11, 16'hC002, 1'b1);
      do_read(20'h05501, 2'b11, 1'b0, d);
      chk("R8 page hit readback", 32'(d), 32'hC001);
      chk("R8 one row opening for three accesses", 32'(ras_falls - f0), 32'd1);
      settle(10);
      chk("R9 row closed after last access", 32'(dram_ras_n), 32'd1);
   endtask

   task automatic t_row_miss;
      int f0;
      logic [15:0] d;
      f0 = ras_falls;
      do_req(1'b1, 20'h00610, 2'b11, 16'h6060, 1'b1);
      do_req(1'b1, 20'h00710, 2'b11, 16'h7070, 1'b0);
      settle(12);
      chk("R10 miss reopens row", 32'(ras_falls - f0), 32'd2);
      do_read(20'h00610, 2'b11, 1'b0, d);
      chk("R10 first row data", 32'(d), 32'h6060);
      settle(10);
      do_read(20'h00710, 2'b11, 1'b0, d);
      chk("R10 second row data", 32'(d), 32'h7070);
      settle(10);
   endtask

   task automatic t_timeout;
      int f0;
      logic [15:0] d;
      f0 = ras_falls;
      max_low = 0;
      for (int k = 0; k < 10; k++)
         do_req(1'b1, {12'h321, 8'(k)}, 2'b11, 16'hB000 + 16'(k), 1'b1);
      do_req(1'b1, 20'h3210A, 2'b11, 16'hB00A, 1'b0);
      settle(12);
      chk("R11 long burst forced a reopen", 32'(ras_falls - f0 >= 2), 32'd1);
      chk("R11 row low at most limit", 32'(max_low <= TB_MAX), 32'd1);
      do_read(20'h32107, 2'b11, 1'b0, d);
      chk("R11 data across reopen", 32'(d), 32'hB007);
      settle(10);
   endtask

   task automatic t_handshake;
      int c0;
      c0 = cas_falls;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h44444;
      req_be = 2'b11; req_wdata = 16'h4444; req_burst = 1'b0;
      #1;
      chk("R12 ready while idle", 32'(req_ready), 32'd1);
      @(negedge clk); #1;
      chk("R12 ready low after take", 32'(req_ready), 32'd0);
      req_valid = 1'b0;
      settle(14);
      chk("R12 one strobe fall per request", 32'(cas_falls - c0), 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_byte_lanes();
      t_page_hit();
      t_row_miss();
      t_timeout();
      t_handshake();
      chk("R6 strobe spacing violations", 32'(sp_bad), 32'd0);
      chk("R7 precharge violations", 32'(rp_bad), 32'd0);
      chk("R4 early-write violations total", 32'(early_bad + wr_oe_bad), 32'd0);
      finish_run();
   end
endmodule